// File: doc/BRIEF.md
# AXI4 Read-Modify-Write Engine

This block is a free-running AXI4 memory-mapped master that performs a single batch update of a fixed memory window. When reset is released it reads a block of 32-bit words, starting at a fixed internal address of zero, in one incrementing burst. The words go into a local input buffer. The block then adds the constant 100 to every word, stores the sums in a second local buffer, and writes them back to the same addresses in one incrementing burst over the same master port.

The engine has no slave-side control path. It takes no start command and has no programmable address. The only way to request a new pass is to apply reset again. Two status outputs are available: a completion flag that stays high once the write response has been accepted, and a sticky flag that records any non-OKAY read or write response. A faulty response does not stop the pass.

Top module: `axi_rmw_engine`

## Requirements
- R1: After reset is released, exactly one read address is issued. Its fields are: address 0, length WORDS-1 (31), size code 3'b010 (4 bytes), burst code 2'b01 (INCR).
- R2: When ARVALID, AWVALID or WVALID is high and the matching READY is low, the same VALID is still high on the next cycle. While a write beat is stalled, WDATA and WLAST do not change.
- R3: RREADY is high only after the read address has been accepted and before the 32nd read beat. BREADY is high only after all 32 write beats have been accepted.
- R4: Write beat k carries (read word k + 100) modulo 2^32. After a pass, memory word k holds that value, so the update is in place.
- R5: Exactly one write address is issued: address 0, length 31, size code 3'b010, burst code 2'b01. Every beat has WSTRB = 4'hF, and WLAST is high only on beat 32.
- R6: Neither AWVALID nor WVALID goes high until all 32 read beats have been accepted.
- R7: DONE goes high only after the write response has been accepted. It then stays high, and ARVALID, AWVALID, WVALID, RREADY and BREADY stay low.
- R8: ERR is set by a read beat whose RRESP is not 2'b00 or by a write response whose BRESP is not 2'b00. ERR stays set until reset, and the pass still finishes with correct write data.
- R9: While reset is high, all VALID and READY outputs, DONE and ERR are low.
- R10: If reset is asserted in the middle of a pass, the pass is abandoned. Releasing reset starts a complete new pass from the first read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; releasing it starts a pass |
| m_araddr | output | ADDR_W | Read burst start address (fixed) |
| m_arlen | output | 8 | Read burst length minus one |
| m_arsize | output | 3 | Read beat size code |
| m_arburst | output | 2 | Read burst type |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response |
| m_rlast | input | 1 | Last read beat |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_awaddr | output | ADDR_W | Write burst start address (fixed) |
| m_awlen | output | 8 | Write burst length minus one |
| m_awsize | output | 3 | Write beat size code |
| m_awburst | output | 2 | Write burst type |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write byte strobes |
| m_wlast | output | 1 | Last write beat |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| done | output | 1 | Pass complete, held until reset |
| err | output | 1 | Sticky non-OKAY response flag |

## Verification
The hardest case to produce is a write beat that is stalled while the output buffer's registered read port has to keep presenting the same word. The next word must then appear only in the cycle after the handshake. A bench memory model reaches this case by dropping WREADY at random, with a fixed seed, on many beats of every pass.

Two other cases are set up with directed passes. One gives an error response on a single read beat in the middle of the burst, and another gives an error write response. A third pass asserts reset partway through the read burst and then runs a complete new pass. Chosen data patterns near 2^32 exercise the wraparound of the add.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AR,
    ST_R,
    ST_PROC,
    ST_AW,
    ST_W,
    ST_B,
    ST_DONE
  } rmw_state_e;

  localparam logic [1:0] AXI_BURST_INCR = 2'b01;
  localparam logic [1:0] AXI_RESP_OKAY  = 2'b00;

endpackage

// File: rtl/rmw_buf.sv
// Simple dual-port buffer, registered read, no reset on storage (block RAM friendly).
module rmw_buf #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/rmw_seq.sv
// Phase sequencer and shared beat/element counter.
module rmw_seq
  import rmw_pkg::*;
#(
  parameter int WORDS = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ar_fire,
  input  logic             r_fire,
  input  logic             aw_fire,
  input  logic             w_fire,
  input  logic             b_fire,
  output rmw_state_e       state,
  output logic [CNT_W-1:0] idx
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORDS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: state <= ST_AR;
        ST_AR:   if (ar_fire) state <= ST_R;
        ST_R: begin
          if (r_fire) begin
            if (idx == LAST) begin
              state <= ST_PROC;
              idx   <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_PROC: begin
          if (idx == FULL) begin
            state <= ST_AW;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_AW: if (aw_fire) state <= ST_W;
        ST_W: begin
          if (w_fire) begin
            if (idx == LAST) begin
              state <= ST_B;
              idx   <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_B:    if (b_fire) state <= ST_DONE;
        default: state <= ST_DONE;
      endcase
    end
  end

  // R6
  proc_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PROC && idx == '0) |-> $past(r_fire));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |=> (state == ST_DONE));

  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_W) |-> (idx <= LAST));

endmodule

// File: rtl/rmw_xform.sv
// Element transform stage: turns a registered buffer read into an add-constant write.
module rmw_xform #(
  parameter int          WIDTH = 32,
  parameter int          AW    = 5,
  parameter logic [31:0] ADD   = 32'd100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [AW-1:0]    rd_idx,
  input  logic [WIDTH-1:0] src_data,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [WIDTH-1:0] wr_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
    end else begin
      wr_en   <= active;
      wr_addr <= rd_idx;
    end
  end

  assign wr_data = src_data + WIDTH'(ADD);

  // R4
  wr_follows_rd_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr == $past(rd_idx)));

endmodule

// File: rtl/axi_rmw_engine.sv
module axi_rmw_engine
  import rmw_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter int          WORDS     = 32,
  parameter logic [31:0] ADD_CONST = 32'd100,
  parameter logic [31:0] BASE_ADDR = 32'd0
) (
  input  logic                clk,
  input  logic                rst,
  output logic [ADDR_W-1:0]   m_araddr,
  output logic [7:0]          m_arlen,
  output logic [2:0]          m_arsize,
  output logic [1:0]          m_arburst,
  output logic                m_arvalid,
  input  logic                m_arready,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic [1:0]          m_rresp,
  input  logic                m_rlast,
  input  logic                m_rvalid,
  output logic                m_rready,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [7:0]          m_awlen,
  output logic [2:0]          m_awsize,
  output logic [1:0]          m_awburst,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  output logic                m_wvalid,
  input  logic                m_wready,
  input  logic [1:0]          m_bresp,
  input  logic                m_bvalid,
  output logic                m_bready,
  output logic                done,
  output logic                err
);

  localparam int               AW        = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int               CNT_W     = $clog2(WORDS + 1);
  localparam int               STRB_W    = DATA_W / 8;
  localparam logic [2:0]       SIZE_CODE = 3'($clog2(STRB_W));
  localparam logic [7:0]       LEN_CODE  = 8'(WORDS - 1);
  localparam logic [CNT_W-1:0] LAST      = CNT_W'(WORDS - 1);
  localparam logic [CNT_W-1:0] FULL      = CNT_W'(WORDS);

  rmw_state_e       state;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] idx_next;

  logic ar_fire, r_fire, aw_fire, w_fire, b_fire;

  logic [DATA_W-1:0] in_rd_data;
  logic [DATA_W-1:0] out_rd_data;
  logic [AW-1:0]     out_rd_addr;
  logic              proc_active;
  logic              xf_wr_en;
  logic [AW-1:0]     xf_wr_addr;
  logic [DATA_W-1:0] xf_wr_data;

  // Fixed burst descriptors
  assign m_araddr  = ADDR_W'(BASE_ADDR);
  assign m_arlen   = LEN_CODE;
  assign m_arsize  = SIZE_CODE;
  assign m_arburst = AXI_BURST_INCR;
  assign m_awaddr  = ADDR_W'(BASE_ADDR);
  assign m_awlen   = LEN_CODE;
  assign m_awsize  = SIZE_CODE;
  assign m_awburst = AXI_BURST_INCR;
  assign m_wstrb   = {STRB_W{1'b1}};

  // Channel controls decoded from the registered phase
  assign m_arvalid = (state == ST_AR);
  assign m_rready  = (state == ST_R);
  assign m_awvalid = (state == ST_AW);
  assign m_wvalid  = (state == ST_W);
  assign m_wlast   = (state == ST_W) && (idx == LAST);
  assign m_bready  = (state == ST_B);
  assign done      = (state == ST_DONE);

  assign ar_fire = m_arvalid && m_arready;
  assign r_fire  = m_rready  && m_rvalid;
  assign aw_fire = m_awvalid && m_awready;
  assign w_fire  = m_wvalid  && m_wready;
  assign b_fire  = m_bready  && m_bvalid;

  rmw_seq #(
    .WORDS (WORDS),
    .CNT_W (CNT_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .ar_fire (ar_fire),
    .r_fire  (r_fire),
    .aw_fire (aw_fire),
    .w_fire  (w_fire),
    .b_fire  (b_fire),
    .state   (state),
    .idx     (idx)
  );

  // Input buffer: filled by read beats, drained by the transform stage
  rmw_buf #(
    .DEPTH (WORDS),
    .WIDTH (DATA_W),
    .AW    (AW)
  ) u_in_buf (
    .clk     (clk),
    .wr_en   (r_fire),
    .wr_addr (idx[AW-1:0]),
    .wr_data (m_rdata),
    .rd_addr (idx[AW-1:0]),
    .rd_data (in_rd_data)
  );

  assign proc_active = (state == ST_PROC) && (idx < FULL);

  rmw_xform #(
    .WIDTH (DATA_W),
    .AW    (AW),
    .ADD   (ADD_CONST)
  ) u_xform (
    .clk      (clk),
    .rst      (rst),
    .active   (proc_active),
    .rd_idx   (idx[AW-1:0]),
    .src_data (in_rd_data),
    .wr_en    (xf_wr_en),
    .wr_addr  (xf_wr_addr),
    .wr_data  (xf_wr_data)
  );

  // Output buffer read address runs one beat ahead on each accepted write beat,
  // so the registered read port always presents the current beat's word.
  assign idx_next    = idx + 1'b1;
  assign out_rd_addr = (state == ST_W && w_fire) ? idx_next[AW-1:0] : idx[AW-1:0];

  rmw_buf #(
    .DEPTH (WORDS),
    .WIDTH (DATA_W),
    .AW    (AW)
  ) u_out_buf (
    .clk     (clk),
    .wr_en   (xf_wr_en),
    .wr_addr (xf_wr_addr),
    .wr_data (xf_wr_data),
    .rd_addr (out_rd_addr),
    .rd_data (out_rd_data)
  );

  assign m_wdata = out_rd_data;

  // Sticky response error
  always_ff @(posedge clk) begin
    if (rst) begin
      err <= 1'b0;
    end else if ((r_fire && m_rresp != AXI_RESP_OKAY) ||
                 (b_fire && m_bresp != AXI_RESP_OKAY)) begin
      err <= 1'b1;
    end
  end

  // R2
  ar_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_arvalid && !m_arready) |=> m_arvalid);

  // R2
  aw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_awvalid && !m_awready) |=> m_awvalid);

  // R2
  w_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata) && $stable(m_wlast)));

  // R3
  rlast_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (r_fire && m_rlast) |=> !m_rready);

  // R5
  wlast_end_chk: assert property (@(posedge clk) disable iff (rst)
    (w_fire && m_wlast) |=> (!m_wvalid && m_bready));

  // R7
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!m_arvalid && !m_awvalid && !m_wvalid && !m_rready && !m_bready));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  // R8
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    ((r_fire && m_rresp != AXI_RESP_OKAY) || (b_fire && m_bresp != AXI_RESP_OKAY)) |=> err);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

endmodule

// File: tb/axi_rmw_engine_bench.sv
module axi_rmw_engine_bench;

  localparam int WORDS = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst;
  logic [31:0] m_araddr, m_awaddr;
  logic [7:0]  m_arlen, m_awlen;
  logic [2:0]  m_arsize, m_awsize;
  logic [1:0]  m_arburst, m_awburst;
  logic        m_arvalid, m_arready;
  logic [31:0] m_rdata;
  logic [1:0]  m_rresp;
  logic        m_rlast, m_rvalid, m_rready;
  logic        m_awvalid, m_awready;
  logic [31:0] m_wdata;
  logic [3:0]  m_wstrb;
  logic        m_wlast, m_wvalid, m_wready;
  logic [1:0]  m_bresp;
  logic        m_bvalid, m_bready;
  logic        done, err;

  axi_rmw_engine u_axi_rmw_engine (
    .clk(clk), .rst(rst),
    .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize), .m_arburst(m_arburst),
    .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rlast(m_rlast), .m_rvalid(m_rvalid),
    .m_rready(m_rready),
    .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
    .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_wvalid(m_wvalid),
    .m_wready(m_wready),
    .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
    .done(done), .err(err)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] mem  [WORDS];
  logic [31:0] orig [WORDS];

  function automatic logic [31:0] expect_word(input logic [31:0] x);
    return x + 32'd100;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    m_arready = 1'b0; m_awready = 1'b0; m_wready = 1'b0;
    m_rvalid = 1'b0; m_rdata = '0; m_rresp = 2'b00; m_rlast = 1'b0;
    m_bvalid = 1'b0; m_bresp = 2'b00;
  endtask

  function automatic bit coin(input int stall);
    if (stall == 0) return 1'b1;
    return ($urandom_range(0, 2) != 0);
  endfunction

  task automatic do_reset(input int cycles);
    rst = 1'b1;
    idle_inputs();
    repeat (cycles) @(posedge clk);
    @(negedge clk);
    // R9 / R10: reset state at the ports
    check(!m_arvalid && !m_awvalid && !m_wvalid, "R9", "valids in reset",
          {29'd0, m_arvalid, m_awvalid, m_wvalid}, 32'd0);
    check(!m_rready && !m_bready, "R9", "readies in reset", {30'd0, m_rready, m_bready}, 32'd0);
    check(!done && !err, "R9", "done/err in reset", {30'd0, done, err}, 32'd0);
    rst = 1'b0;
    for (int i = 0; i < WORDS; i++) orig[i] = mem[i];
  endtask

  task automatic run_pass(input int stall, input int r_err_idx, input bit b_err, input int abort_at);
    int ar_n = 0, aw_n = 0, rbeat = 0, wbeat = 0, cyc = 0;
    bit bdone = 1'b0, r_hold = 1'b0, b_hold = 1'b0;
    bit prev_ar_wait = 1'b0, prev_aw_wait = 1'b0, prev_w_wait = 1'b0;
    logic [31:0] prev_wdata = '0;
    logic prev_wlast = 1'b0;
    bit exp_err = (r_err_idx >= 0) || b_err;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (abort_at > 0 && cyc == abort_at) return;
      if (cyc > 3000) begin
        check(1'b0, "R7", "pass did not complete", {31'd0, done}, 32'd1);
        return;
      end
      // R2 stability of stalled requests
      if (prev_ar_wait) check(m_arvalid === 1'b1, "R2", "ARVALID dropped", {31'd0, m_arvalid}, 32'd1);
      if (prev_aw_wait) check(m_awvalid === 1'b1, "R2", "AWVALID dropped", {31'd0, m_awvalid}, 32'd1);
      if (prev_w_wait) begin
        check(m_wvalid === 1'b1, "R2", "WVALID dropped", {31'd0, m_wvalid}, 32'd1);
        check(m_wdata === prev_wdata, "R2", "WDATA changed while stalled", m_wdata, prev_wdata);
        check(m_wlast === prev_wlast, "R2", "WLAST changed while stalled", {31'd0, m_wlast}, {31'd0, prev_wlast});
      end
      // R3 ready windows
      if (m_rready) check(ar_n == 1 && rbeat < WORDS, "R3", "RREADY outside read phase", rbeat, 32'd0);
      if (m_bready) check(wbeat == WORDS, "R3", "BREADY before all write beats", wbeat, WORDS);
      // R6 ordering
      if (m_awvalid || m_wvalid) check(rbeat == WORDS, "R6", "write started early", rbeat, WORDS);
      if (done) break;

      // Slave-driven valids, decided from state before this edge's handshakes
      if (!r_hold) begin
        m_rvalid = (ar_n == 1) && (rbeat < WORDS) && coin(stall);
        if (m_rvalid) begin
          m_rdata = mem[rbeat];
          m_rlast = (rbeat == WORDS - 1);
          m_rresp = (rbeat == r_err_idx) ? 2'b10 : 2'b00;
        end else begin
          m_rlast = 1'b0;
          m_rresp = 2'b00;
        end
      end
      if (!b_hold) begin
        m_bvalid = (aw_n == 1) && (wbeat == WORDS) && !bdone && coin(stall);
        m_bresp  = b_err ? 2'b10 : 2'b00;
      end
      m_arready = coin(stall);
      m_awready = coin(stall);
      m_wready  = coin(stall);

      if (m_arvalid && m_arready) begin
        // R1
        check(ar_n == 0, "R1", "extra read address", ar_n, 32'd0);
        check(m_araddr == 32'd0, "R1", "ARADDR", m_araddr, 32'd0);
        check(m_arlen == 8'd31 && m_arsize == 3'b010 && m_arburst == 2'b01, "R1", "AR len/size/burst",
              {16'd0, m_arlen, 3'd0, m_arsize, m_arburst}, {16'd0, 8'd31, 3'd0, 3'b010, 2'b01});
        ar_n++;
      end
      if (m_awvalid && m_awready) begin
        // R5
        check(aw_n == 0, "R5", "extra write address", aw_n, 32'd0);
        check(m_awaddr == 32'd0, "R5", "AWADDR", m_awaddr, 32'd0);
        check(m_awlen == 8'd31 && m_awsize == 3'b010 && m_awburst == 2'b01, "R5", "AW len/size/burst",
              {16'd0, m_awlen, 3'd0, m_awsize, m_awburst}, {16'd0, 8'd31, 3'd0, 3'b010, 2'b01});
        aw_n++;
      end
      if (m_wvalid && m_wready) begin
        if (wbeat < WORDS) begin
          // R4
          check(m_wdata === expect_word(orig[wbeat]), "R4", "write data", m_wdata, expect_word(orig[wbeat]));
          // R5
          check(m_wstrb === 4'hF, "R5", "WSTRB", {28'd0, m_wstrb}, 32'hF);
          check(m_wlast === (wbeat == WORDS - 1), "R5", "WLAST position", {31'd0, m_wlast},
                {31'd0, (wbeat == WORDS - 1)});
          mem[wbeat] = m_wdata;
        end else begin
          check(1'b0, "R5", "write beat beyond burst", wbeat, WORDS);
        end
        wbeat++;
      end
      if (m_rvalid && m_rready) begin
        rbeat++;
        r_hold = 1'b0;
      end else begin
        r_hold = m_rvalid;
      end
      if (m_bvalid && m_bready) begin
        bdone  = 1'b1;
        b_hold = 1'b0;
      end else begin
        b_hold = m_bvalid;
      end
      prev_ar_wait = m_arvalid && !m_arready;
      prev_aw_wait = m_awvalid && !m_awready;
      prev_w_wait  = m_wvalid && !m_wready;
      prev_wdata   = m_wdata;
      prev_wlast   = m_wlast;
    end

    // R7 completion
    check(bdone, "R7", "DONE before write response", {31'd0, bdone}, 32'd1);
    check(wbeat == WORDS && rbeat == WORDS, "R7", "beat totals", wbeat, WORDS);
    // R8 error flag
    check(err === exp_err, "R8", "ERR after pass", {31'd0, err}, {31'd0, exp_err});
    idle_inputs();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(done === 1'b1 && !m_arvalid && !m_awvalid && !m_wvalid && !m_rready && !m_bready,
            "R7", "quiet after DONE",
            {26'd0, done, m_arvalid, m_awvalid, m_wvalid, m_rready, m_bready}, 32'h20);
      check(err === exp_err, "R8", "ERR held", {31'd0, err}, {31'd0, exp_err});
    end
    // R4 in-place update
    for (int i = 0; i < WORDS; i++)
      check(mem[i] === expect_word(orig[i]), "R4", "memory after pass", mem[i], expect_word(orig[i]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R7 watchdog expired: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    rst = 1'b1;
    idle_inputs();

    // Directed: ascending data, no stalls
    for (int i = 0; i < WORDS; i++) mem[i] = i * 32'h0101_0101;
    do_reset(3);
    run_pass(0, -1, 1'b0, 0);

    // Second pass over the updated memory with random stalls
    do_reset(2);
    run_pass(1, -1, 1'b0, 0);

    // Random data, random stalls
    for (int i = 0; i < WORDS; i++) mem[i] = $urandom();
    do_reset(2);
    run_pass(1, -1, 1'b0, 0);

    // Wraparound values, error response on read beat 5
    for (int i = 0; i < WORDS; i++) mem[i] = 32'hFFFF_FFFF - 32'(i * 7);
    do_reset(2);
    run_pass(1, 5, 1'b0, 0);

    // Zeros, error write response
    for (int i = 0; i < WORDS; i++) mem[i] = '0;
    do_reset(2);
    run_pass(1, -1, 1'b1, 0);

    // R10: reset during the read burst, then a full pass
    for (int i = 0; i < WORDS; i++) mem[i] = $urandom();
    do_reset(2);
    run_pass(1, -1, 1'b0, 20);
    do_reset(2);
    run_pass(1, -1, 1'b0, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule